// File: doc/BRIEF.md
# Cache Victim-Way Selector with Switchable Replacement Policy

This block decides which way of a 4-way set-associative cache is overwritten on the next miss, and keeps the replacement history of every set. The cache pipeline presents a set index each cycle. It reports hits with the way that hit, and it raises a fill strobe when a missed line is written. The block answers with a victim way for the presented set. The answer is combinational from the registered per-set state and the current inputs.

Three rules can be chosen at run time. The first is a 3-bit binary tree per set that approximates least-recently-used. The second is a per-set rotating pointer, first-in first-out. The third is a 2-bit draw from a free-running 16-bit linear-feedback shift register. The tree state and the pointer state are both kept up to date whatever rule is selected, so switching rules takes effect on the very next lookup.

Before any rule is applied, a way whose valid bit is clear is preferred. Each access is classed by a small event decoder into one of three events:
- idle (`EV_NONE`)
- hit update (`EV_HIT`)
- fill update (`EV_FILL`)

The selected rule is one of four policy codes:
- tree (`POL_PLRU`)
- rotate (`POL_FIFO`)
- random (`POL_RAND`)
- spare (`POL_ALT`)

Top module: `repl_policy_unit`

## Requirements
- R1: After reset every set's tree bits and rotating pointer are zero, so with all ways valid the victim is way 0 under policy code 0 (tree) and policy code 1 (rotate) for every set.
- R2: When `way_valid` (bit i = way i holds a line) has any bit clear, the victim is the lowest-numbered way whose bit is clear, under every policy. A fill in that state writes that way.
- R3: A hit (`acc_valid`=1, `acc_hit`=1) on way w updates the addressed set's tree so that it points away from w:
  - the root bit becomes the inverse of w[1];
  - the pair bit on w's side becomes the inverse of w[0].

  The tree victim is found from the root: root 0 picks between ways 0 and 1 using the left bit, and root 1 picks between ways 2 and 3 using the right bit. A bit value of 1 selects the higher way.
- R4: A fill (`fill_valid`=1) updates the addressed set's tree with the same rule, using the way being filled.
- R5: Each fill advances the addressed set's rotating pointer by one, modulo 4. Under policy code 1 with all ways valid, the victim equals that pointer.
- R6: Hits never move the rotating pointer.
- R7: Under policy code 2 with all ways valid, the victim is taken from a free-running nonzero 16-bit LFSR reduced to 2 bits. Over 64 consecutive cycles it shows at least three distinct ways.
- R8: An update to one set leaves every other set's tree and pointer unchanged.
- R9: Policy code 3 selects the same victim as policy code 0.
- R10: Tree and pointer state are updated on hits and fills whatever policy is selected at the time.
- R11: When a hit and a fill are presented in the same cycle, only the hit is applied. The tree follows the hit way and the pointer does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | A lookup to `acc_set` is performed this cycle |
| acc_set | input | SET_W | Set index of the lookup, fill and victim query |
| acc_hit | input | 1 | The lookup hit |
| hit_way | input | 2 | Way that hit |
| fill_valid | input | 1 | A missed line is written into the victim way of `acc_set` |
| way_valid | input | 4 | Valid bits of the addressed set, bit i for way i |
| policy_sel | input | 2 | 0 tree, 1 rotate, 2 random, 3 same as tree |
| victim_way | output | 2 | Way to replace in `acc_set` |

## Verification
The assertions assume a few things about the inputs:
- `acc_set` names an existing set.
- `hit_way` carries meaning only while `acc_valid` and `acc_hit` are both high.
- `way_valid` reflects the addressed set at the time of the query.

The stimulus drives every control one nanosecond after a rising edge and holds it for a full cycle, and indexes only sets below the parameterised count. Fills are issued only under tree or rotate policy with a known valid mask, so the way being written is always predictable from the requirements. Hit-plus-fill collisions are raised deliberately, once, to exercise the priority rule.

// File: rtl/rpu_pkg.sv
`timescale 1ns/1ps
package rpu_pkg;

    localparam int WAYS   = 4;
    localparam int WAY_W  = 2;
    localparam int TREE_W = 3;

    typedef enum logic [1:0] {
        POL_PLRU = 2'd0,
        POL_FIFO = 2'd1,
        POL_RAND = 2'd2,
        POL_ALT  = 2'd3
    } policy_e;

    typedef enum logic [1:0] {
        EV_NONE = 2'd0,
        EV_HIT  = 2'd1,
        EV_FILL = 2'd2
    } event_e;

    // Follow the tree from its root: bit0 root, bit1 left pair, bit2 right pair.
    function automatic logic [WAY_W-1:0] tree_pick(input logic [TREE_W-1:0] t);
        logic [WAY_W-1:0] w;
        w[1] = t[0];
        w[0] = t[0] ? t[2] : t[1];
        return w;
    endfunction

    // Point the path bits away from the way just used.
    function automatic logic [TREE_W-1:0] tree_touch(input logic [TREE_W-1:0] t,
                                                     input logic [WAY_W-1:0]  w);
        logic [TREE_W-1:0] n;
        n    = t;
        n[0] = ~w[1];
        if (w[1]) n[2] = ~w[0];
        else      n[1] = ~w[0];
        return n;
    endfunction

    // Lowest-numbered way whose valid bit is clear (0 when none is clear).
    function automatic logic [WAY_W-1:0] first_free(input logic [WAYS-1:0] vld);
        logic [WAY_W-1:0] w;
        w = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (!vld[i]) w = WAY_W'(i);
        end
        return w;
    endfunction

endpackage

// File: rtl/rpu_plru_store.sv
`timescale 1ns/1ps
module rpu_plru_store
    import rpu_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int SET_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SET_W-1:0]    set_idx,
    input  logic [WAY_W-1:0]    wr_way,
    output logic [TREE_W-1:0]   rd_tree
);

    logic [TREE_W-1:0] tree_q [NUM_SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) tree_q[s] <= '0;
        end else if (wr_en) begin
            tree_q[set_idx] <= tree_touch(tree_q[set_idx], wr_way);
        end
    end

    assign rd_tree = tree_q[set_idx];

    // R3 / R4: the way just touched is never the next tree victim of that set
    a_r3_touched_not_victim: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> tree_pick(tree_q[$past(set_idx)]) != $past(wr_way));

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
            // R8: sets not addressed keep their tree bits
            a_r8_tree_isolated: assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && set_idx == SET_W'(s)) |=> $stable(tree_q[s]));
        end
    endgenerate

endmodule

// File: rtl/rpu_rr_store.sv
`timescale 1ns/1ps
module rpu_rr_store
    import rpu_pkg::*;
#(
    parameter int NUM_SETS = 8,
    parameter int SET_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv_en,
    input  logic [SET_W-1:0]    set_idx,
    output logic [WAY_W-1:0]    rd_ptr
);

    logic [WAY_W-1:0] ptr_q [NUM_SETS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++) ptr_q[s] <= '0;
        end else if (adv_en) begin
            ptr_q[set_idx] <= ptr_q[set_idx] + WAY_W'(1);
        end
    end

    assign rd_ptr = ptr_q[set_idx];

    // R5: a fill moves the addressed pointer forward by exactly one
    a_r5_fill_steps_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        adv_en |=> ptr_q[$past(set_idx)] == WAY_W'($past(ptr_q[set_idx]) + WAY_W'(1)));

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_hold
            // R6 / R8: without a fill to this set its pointer is unchanged
            a_r6_ptr_held: assert property (@(posedge clk) disable iff (!rst_n)
                !(adv_en && set_idx == SET_W'(s)) |=> $stable(ptr_q[s]));
        end
    endgenerate

endmodule

// File: rtl/rpu_lfsr.sv
`timescale 1ns/1ps
module rpu_lfsr #(
    parameter int          LEN   = 16,
    parameter logic [15:0] SEED  = 16'hACE1,
    parameter logic [15:0] TAPS  = 16'hB400,
    parameter int          OUT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] rnd
);

    logic [LEN-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SEED[LEN-1:0];
        else        state_q <= {1'b0, state_q[LEN-1:1]} ^ (state_q[0] ? TAPS[LEN-1:0] : '0);
    end

    assign rnd = state_q[OUT_W-1:0];

    // R7: the generator never locks up in the all-zero state
    a_r7_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    // R7: it keeps running every cycle
    a_r7_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != '0) |=> state_q != $past(state_q));

endmodule

// File: rtl/repl_policy_unit.sv
`timescale 1ns/1ps
module repl_policy_unit
    import rpu_pkg::*;
#(
    parameter int          NUM_SETS = 8,
    parameter logic [15:0] RND_SEED = 16'hACE1,
    localparam int         SET_W    = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SET_W-1:0]  acc_set,
    input  logic              acc_hit,
    input  logic [1:0]        hit_way,
    input  logic              fill_valid,
    input  logic [3:0]        way_valid,
    input  logic [1:0]        policy_sel,
    output logic [1:0]        victim_way
);

    event_e            ev;
    policy_e           pol;
    logic [WAY_W-1:0]  touch_way;
    logic [TREE_W-1:0] tree_rd;
    logic [WAY_W-1:0]  ptr_rd;
    logic [WAY_W-1:0]  rnd_rd;
    logic [WAY_W-1:0]  pol_pick;

    assign pol = policy_e'(policy_sel);

    // Event classification: a hit outranks a fill in the same cycle
    always_comb begin
        if (acc_valid && acc_hit) ev = EV_HIT;
        else if (fill_valid)      ev = EV_FILL;
        else                      ev = EV_NONE;
    end

    // Way that the update event refers to
    always_comb begin
        unique case (ev)
            EV_HIT:  touch_way = hit_way;
            EV_FILL: touch_way = victim_way;
            default: touch_way = '0;
        endcase
    end

    rpu_plru_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_plru (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (ev != EV_NONE),
        .set_idx (acc_set),
        .wr_way  (touch_way),
        .rd_tree (tree_rd)
    );

    rpu_rr_store #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .adv_en  (ev == EV_FILL),
        .set_idx (acc_set),
        .rd_ptr  (ptr_rd)
    );

    rpu_lfsr #(.SEED(RND_SEED), .OUT_W(WAY_W)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .rnd   (rnd_rd)
    );

    // Output process: policy decision, overridden by a free way
    always_comb begin
        unique case (pol)
            POL_FIFO:           pol_pick = ptr_rd;
            POL_RAND:           pol_pick = rnd_rd;
            POL_PLRU, POL_ALT:  pol_pick = tree_pick(tree_rd);
        endcase
        victim_way = (&way_valid) ? pol_pick : first_free(way_valid);
    end

    // R2: an empty way is always the one offered
    a_r2_free_way_first: assert property (@(posedge clk) disable iff (!rst_n)
        !(&way_valid) |-> !way_valid[victim_way]);

    // R11: with hit and fill together the pointer of the set must not move
    a_r11_hit_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_hit && fill_valid && pol == POL_FIFO && (&way_valid))
        |=> ($past(acc_set) != acc_set) || ($past(victim_way) == victim_way)
            || ($past(policy_sel) != policy_sel) || !(&way_valid));

endmodule

// File: tb/repl_policy_unit_bench.sv
`timescale 1ns/1ps
module repl_policy_unit_bench;

    localparam int NS = 8;
    localparam int SW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic          acc_hit = 1'b0;
    logic [1:0]    hit_way = '0;
    logic          fill_valid = 1'b0;
    logic [3:0]    way_valid = 4'hF;
    logic [1:0]    policy_sel = '0;
    logic [1:0]    victim_way;

    always #2.5 clk = ~clk;

    repl_policy_unit #(.NUM_SETS(NS)) u_repl_policy_unit (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
        .acc_hit(acc_hit), .hit_way(hit_way), .fill_valid(fill_valid),
        .way_valid(way_valid), .policy_sel(policy_sel), .victim_way(victim_way)
    );

    typedef struct { logic [1:0] exp; string tag; } item_t;
    item_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [2:0] tree_m [NS];
    logic [1:0] ptr_m  [NS];

    // Reference rules written from the requirement text
    function automatic logic [1:0] m_tree_victim(logic [2:0] t);
        case ({t[0], t[1], t[2]})
            3'b000, 3'b001: return 2'd0;
            3'b010, 3'b011: return 2'd1;
            3'b100, 3'b110: return 2'd2;
            default:        return 2'd3;
        endcase
    endfunction

    function automatic logic [2:0] m_touch(logic [2:0] t, logic [1:0] w);
        case (w)
            2'd0: return {t[2], 1'b1, 1'b1};
            2'd1: return {t[2], 1'b0, 1'b1};
            2'd2: return {1'b1, t[1], 1'b0};
            default: return {1'b0, t[1], 1'b0};
        endcase
    endfunction

    function automatic logic [1:0] m_victim(int s, int pol, logic [3:0] vld);
        if (vld != 4'hF) begin
            for (int i = 0; i < 4; i++) if (!vld[i]) return 2'(i);
        end
        if (pol == 1) return ptr_m[s];
        return m_tree_victim(tree_m[s]);
    endfunction

    // Monitor: compares each queued expectation at the falling edge
    always @(negedge clk) begin
        item_t it;
        if (sbq.size() > 0) begin
            it = sbq.pop_front();
            n_chk++;
            if (victim_way !== it.exp) begin
                n_fail++;
                $display("FAIL %s: victim_way=%0d expected %0d", it.tag, victim_way, it.exp);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(int s, int pol, logic [3:0] vld, string tag);
        step();
        acc_valid = 0; acc_hit = 0; fill_valid = 0;
        acc_set = SW'(s); policy_sel = 2'(pol); way_valid = vld;
        sbq.push_back('{m_victim(s, pol, vld), tag});
    endtask

    task automatic do_hit(int s, int w, int pol, bit with_fill);
        step();
        acc_valid = 1; acc_hit = 1; hit_way = 2'(w); fill_valid = with_fill;
        acc_set = SW'(s); policy_sel = 2'(pol); way_valid = 4'hF;
        tree_m[s] = m_touch(tree_m[s], 2'(w));
    endtask

    task automatic do_fill(int s, int pol, logic [3:0] vld);
        logic [1:0] v;
        step();
        v = m_victim(s, pol, vld);
        acc_valid = 0; acc_hit = 0; fill_valid = 1;
        acc_set = SW'(s); policy_sel = 2'(pol); way_valid = vld;
        tree_m[s] = m_touch(tree_m[s], v);
        ptr_m[s]  = ptr_m[s] + 2'd1;
    endtask

    initial begin
        for (int s = 0; s < NS; s++) begin tree_m[s] = '0; ptr_m[s] = '0; end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk(0, 0, 4'hF, "R1 tree set0");
        chk(7, 0, 4'hF, "R1 tree set7");
        chk(0, 1, 4'hF, "R1 rotate set0");
        chk(7, 1, 4'hF, "R1 rotate set7");

        // R2: free way preference under every policy, and fill into it
        chk(0, 0, 4'b0101, "R2 tree mask0101");
        chk(0, 1, 4'b1011, "R2 rotate mask1011");
        chk(0, 2, 4'b0111, "R2 random mask0111");
        chk(0, 2, 4'b1110, "R2 random mask1110");
        do_fill(1, 0, 4'b0001);
        chk(1, 0, 4'hF, "R2 tree after free fill");
        chk(1, 1, 4'hF, "R2 rotate after free fill");

        // R3: hits steer the tree away
        do_hit(2, 0, 0, 0); chk(2, 0, 4'hF, "R3 after hit0");
        do_hit(2, 2, 0, 0); chk(2, 0, 4'hF, "R3 after hit2");
        do_hit(2, 1, 0, 0); chk(2, 0, 4'hF, "R3 after hit1");
        do_hit(2, 3, 0, 0); chk(2, 0, 4'hF, "R3 after hit3");

        // R9: code 3 mirrors the tree
        chk(2, 3, 4'hF, "R9 spare code");

        // R4: fills steer the tree
        for (int k = 0; k < 4; k++) begin
            do_fill(3, 0, 4'hF);
            chk(3, 0, 4'hF, "R4 tree after fill");
        end

        // R5: rotating pointer steps on fills
        for (int k = 0; k < 5; k++) begin
            do_fill(4, 1, 4'hF);
            chk(4, 1, 4'hF, "R5 rotate after fill");
        end

        // R6: hits leave the pointer alone
        do_hit(4, 0, 1, 0);
        do_hit(4, 1, 1, 0);
        chk(4, 1, 4'hF, "R6 rotate after hits");

        // R8: untouched set remains at reset state
        chk(5, 0, 4'hF, "R8 tree set5");
        chk(5, 1, 4'hF, "R8 rotate set5");

        // R10: state tracked under another policy
        do_fill(6, 0, 4'hF);
        do_fill(6, 0, 4'hF);
        chk(6, 1, 4'hF, "R10 rotate after tree-mode fills");
        do_hit(6, 3, 1, 0);
        chk(6, 0, 4'hF, "R10 tree after rotate-mode hit");

        // R11: hit and fill together, only the hit counts
        do_hit(4, 2, 1, 1);
        chk(4, 1, 4'hF, "R11 pointer unchanged");
        chk(4, 0, 4'hF, "R11 tree follows hit");

        // R7: random draw spreads over ways
        begin
            bit [3:0] seen = '0;
            step();
            acc_valid = 0; acc_hit = 0; fill_valid = 0;
            acc_set = '0; policy_sel = 2'd2; way_valid = 4'hF;
            for (int k = 0; k < 64; k++) begin
                @(negedge clk);
                seen[victim_way] = 1'b1;
            end
            n_chk++;
            if ($countones(seen) < 3) begin
                n_fail++;
                $display("FAIL R7: distinct ways=%0d expected >=3", $countones(seen));
            end
        end

        step(); step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule